// File: doc/BRIEF.md
# USB Host Low-Level Packet Encoder

This block turns a host-side packet request into the bytes a downstream USB serializer puts on the wire. One request describes one of four packet families: a token addressed to a device endpoint (SETUP, IN or OUT), a start-of-frame marker that carries an 11-bit frame number, a one-byte handshake (ACK or NAK), or the one-byte header that opens a data packet. The bytes leave one at a time over a valid/ready pair. A one-cycle `done` pulse closes each packet.

For tokens and start-of-frame markers, the encoder builds the 11-bit field, runs a serial CRC5 over it one bit per clock, and then sends three bytes. For data headers, the encoder keeps the DATA0/DATA1 sequence bit of a single endpoint. It picks the header from that bit and updates the bit when the packet completes. Bit stuffing, NRZI coding, the payload CRC16 and reply handling belong to other blocks.

The reset `rst_n` is active low and asserts asynchronously. The clock domain must release it synchronously.

Top module: `usb_pkt_encoder`

## Requirements
- R1: Every packet starts with a PID byte. Its low nibble is the 4-bit code and its high nibble is the bitwise complement of that code. The codes are SETUP 0xD, IN 0x9, OUT 0x1, SOF 0x5, ACK 0x2, NAK 0xA, DATA0 0x3 and DATA1 0xB, so the bytes are 0x2D, 0x69, 0xE1, 0xA5, 0xD2, 0x5A, 0xC3 and 0x4B.
- R2: `req_kind` selects the packet: 0 SETUP, 1 IN, 2 OUT, 3 start-of-frame, 4 ACK, 5 NAK, 6 data header. Code 7 is ignored: nothing is emitted, no `done` occurs, and the block stays idle.
- R3: A SETUP, IN or OUT token is three bytes: the PID byte, then bits 7:0, then bits 15:8 of a 16-bit word. Bits 6:0 of the word hold `dev_addr`, bits 10:7 hold `endp`, and bits 15:11 hold the CRC5.
- R4: The CRC5 runs over the 11-bit field, least significant bit first. The register starts at 0x1F. For each bit, if the register LSB XOR the input bit is 1, the register shifts right by one and is XORed with 0x14; otherwise it only shifts right. The bitwise complement of the final value is sent.
- R5: A start-of-frame packet is the PID byte 0xA5 followed by the same 16-bit layout. Bits 10:0 carry `frame_num` and bits 15:11 carry its CRC5.
- R6: After a three-byte request is accepted, `out_valid` stays low for the 11 CRC cycles and rises in the 12th cycle. A one-byte packet is offered in the cycle after acceptance.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.
- R8: `out_last` marks the final byte of each packet. `done` is high for exactly one cycle, the cycle after that byte's handshake.
- R9: `req_ready` is high only when the block is idle. Requests presented while it is busy are not taken and do not alter the packet in progress.
- R10: A data header byte is DATA0 (0xC3) or DATA1 (0x4B) according to the sequence bit. The bit inverts each time a data header completes.
- R11: A completed SETUP, IN or OUT token clears the sequence bit to DATA0. Start-of-frame, ACK and NAK leave it unchanged.
- R12: Reset returns the block to idle with `out_valid` and `done` low, `req_ready` high and the sequence bit at DATA0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Block idle, request taken on this cycle |
| req_kind | input | 3 | Packet kind code |
| dev_addr | input | 7 | Device address for tokens |
| endp | input | 4 | Endpoint number for tokens |
| frame_num | input | 11 | Frame number for start-of-frame |
| out_data | output | 8 | Byte offered to the serializer |
| out_valid | output | 1 | `out_data` valid |
| out_ready | input | 1 | Serializer accepts the byte |
| out_last | output | 1 | Current byte ends the packet |
| done | output | 1 | One-cycle packet-complete pulse |

## Verification
The assertions assume a downstream that may hold `out_ready` low for any number of cycles. They also assume that request fields matter only in the cycle the request is taken. The checks then hold under back-pressure and under requests that arrive while the block is busy. The stimulus drives `out_ready` in a stall pattern that drops it every third cycle and presents competing requests during busy periods. The stimulus also releases reset between clock edges, so the disable condition is never partially met. The IN sweep covers every one of the 2048 address/endpoint values. A long interleaved run of data headers, handshakes, start-of-frame markers and tokens exercises the sequence bit.

// File: rtl/usbenc_pkg.sv
package usbenc_pkg;

  typedef enum logic [2:0] {
    K_SETUP = 3'd0,
    K_IN    = 3'd1,
    K_OUT   = 3'd2,
    K_SOF   = 3'd3,
    K_ACK   = 3'd4,
    K_NAK   = 3'd5,
    K_DATA  = 3'd6,
    K_RSVD  = 3'd7
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CRC  = 3'd1,
    ST_B0   = 3'd2,
    ST_B1   = 3'd3,
    ST_B2   = 3'd4
  } enc_state_e;

  localparam logic [3:0] CODE_SETUP = 4'hD;
  localparam logic [3:0] CODE_IN    = 4'h9;
  localparam logic [3:0] CODE_OUT   = 4'h1;
  localparam logic [3:0] CODE_SOF   = 4'h5;
  localparam logic [3:0] CODE_ACK   = 4'h2;
  localparam logic [3:0] CODE_NAK   = 4'hA;
  localparam logic [3:0] CODE_DATA0 = 4'h3;
  localparam logic [3:0] CODE_DATA1 = 4'hB;

  // check nibble in the upper half, code in the lower half
  function automatic logic [7:0] pid_byte(input logic [3:0] code);
    return {~code, code};
  endfunction

endpackage

// File: rtl/usbenc_crc5.sv
module usbenc_crc5 #(
  parameter int                 CRC_W = 5,
  parameter logic [CRC_W-1:0]   POLY  = 5'h14,
  parameter logic [CRC_W-1:0]   SEED  = 5'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic             din,
  output logic [CRC_W-1:0] crc_out
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;

  assign crc_en = init | step;

  always_comb begin
    crc_d = crc_q;
    if (init) begin
      crc_d = SEED;
    end else if (step) begin
      if (crc_q[0] ^ din) crc_d = (crc_q >> 1) ^ POLY;
      else                crc_d = crc_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_out = ~crc_q;

  // R4: the remainder only moves when seeded or stepped
  p_crc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !step) |=> $stable(crc_out));

endmodule

// File: rtl/usbenc_toggle.sv
module usbenc_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  input  logic clear,
  output logic seq_bit
);

  logic seq_q;
  logic seq_d;
  logic seq_en;

  assign seq_en = flip | clear;

  always_comb begin
    seq_d = seq_q;
    if (clear)     seq_d = 1'b0;
    else if (flip) seq_d = ~seq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seq_q <= 1'b0;
    else if (seq_en) seq_q <= seq_d;
  end

  assign seq_bit = seq_q;

  p_seq_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !clear) |=> (seq_bit != $past(seq_bit)));

  p_seq_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !seq_bit);

endmodule

// File: rtl/usb_pkt_encoder.sv
module usb_pkt_encoder #(
  parameter int ADDR_W = 7,
  parameter int EP_W   = 4,
  parameter int CRC_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [2:0]             req_kind,
  input  logic [ADDR_W-1:0]      dev_addr,
  input  logic [EP_W-1:0]        endp,
  input  logic [ADDR_W+EP_W-1:0] frame_num,
  output logic [7:0]             out_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic                   out_last,
  output logic                   done
);
  import usbenc_pkg::*;

  localparam int FIELD_W = ADDR_W + EP_W;
  localparam int WORD_W  = FIELD_W + CRC_W;
  localparam int CNT_W   = $clog2(FIELD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FIELD_W - 1);

  enc_state_e          state_q, state_d;
  req_kind_e           kind_q, kind_in;
  logic [FIELD_W-1:0]  shift_q, keep_q, field_in;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [7:0]          pid_q, pid_in;
  logic                single_q, single_in;
  logic                done_q;
  logic                accept, hs, finish;
  logic                seq_bit, seq_flip, seq_clear;
  logic [CRC_W-1:0]    crc5;
  logic [WORD_W-1:0]   word;

  assign kind_in   = req_kind_e'(req_kind);
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready && (kind_in != K_RSVD);
  assign hs        = out_valid && out_ready;
  assign finish    = hs && out_last;

  // request decode
  always_comb begin
    single_in = 1'b0;
    field_in  = {endp, dev_addr};
    unique case (kind_in)
      K_SETUP: pid_in = pid_byte(CODE_SETUP);
      K_IN:    pid_in = pid_byte(CODE_IN);
      K_OUT:   pid_in = pid_byte(CODE_OUT);
      K_SOF: begin
        pid_in   = pid_byte(CODE_SOF);
        field_in = frame_num;
      end
      K_ACK: begin
        pid_in    = pid_byte(CODE_ACK);
        single_in = 1'b1;
      end
      K_NAK: begin
        pid_in    = pid_byte(CODE_NAK);
        single_in = 1'b1;
      end
      K_DATA: begin
        pid_in    = seq_bit ? pid_byte(CODE_DATA1) : pid_byte(CODE_DATA0);
        single_in = 1'b1;
      end
      default: pid_in = 8'h00;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept) state_d = single_in ? ST_B0 : ST_CRC;
      end
      ST_CRC: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) state_d = ST_B0;
      end
      ST_B0: if (hs) state_d = single_q ? ST_IDLE : ST_B1;
      ST_B1: if (hs) state_d = ST_B2;
      ST_B2: if (hs) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q   <= K_SETUP;
      pid_q    <= '0;
      single_q <= 1'b0;
      keep_q   <= '0;
    end else if (accept) begin
      kind_q   <= kind_in;
      pid_q    <= pid_in;
      single_q <= single_in;
      keep_q   <= field_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   shift_q <= '0;
    else if (accept)              shift_q <= field_in;
    else if (state_q == ST_CRC)   shift_q <= shift_q >> 1;
  end

  usbenc_crc5 #(.CRC_W(CRC_W)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (accept),
    .step    (state_q == ST_CRC),
    .din     (shift_q[0]),
    .crc_out (crc5)
  );

  assign seq_flip  = finish && (kind_q == K_DATA);
  assign seq_clear = finish && (kind_q == K_SETUP || kind_q == K_IN || kind_q == K_OUT);

  usbenc_toggle u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flip    (seq_flip),
    .clear   (seq_clear),
    .seq_bit (seq_bit)
  );

  // output mux
  assign word      = {crc5, keep_q};
  assign out_valid = (state_q == ST_B0) || (state_q == ST_B1) || (state_q == ST_B2);
  assign out_last  = (state_q == ST_B2) || ((state_q == ST_B0) && single_q);
  assign done      = done_q;

  always_comb begin
    unique case (state_q)
      ST_B1:   out_data = word[7:0];
      ST_B2:   out_data = word[15:8];
      default: out_data = pid_q;
    endcase
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && out_last));

  p_busy_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

  p_crc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_kind <= 3'd3) |=> (!out_valid && !req_ready));

endmodule

// File: tb/usb_pkt_encoder_test.sv
module usb_pkt_encoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_kind;
  logic [6:0]  dev_addr;
  logic [3:0]  endp;
  logic [10:0] frame_num;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready;
  logic        out_last;
  logic        done;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  bit tb_tog  = 1'b0;

  always #2 clk = ~clk;

  usb_pkt_encoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .dev_addr(dev_addr), .endp(endp), .frame_num(frame_num),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 190000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // R4: reference CRC5 from the stated rule
  function automatic logic [4:0] crc5_ref(input logic [10:0] v);
    logic [4:0] x = 5'h1F;
    for (int i = 0; i < 11; i++) begin
      if (x[0] ^ v[i]) x = (x >> 1) ^ 5'h14;
      else             x = x >> 1;
    end
    return ~x;
  endfunction

  task automatic run_pkt(input logic [2:0] kind, input logic [6:0] dev, input logic [3:0] ep,
                         input logic [10:0] frame, input bit stall, input bit poke);
    logic [7:0]  e [3];
    logic [10:0] fld;
    logic [15:0] w;
    logic [7:0]  held;
    int nb, lat, n, idx, first;
    bit hold_pending;
    string tag;
    case (kind)
      3'd0: e[0] = 8'h2D;
      3'd1: e[0] = 8'h69;
      3'd2: e[0] = 8'hE1;
      3'd3: e[0] = 8'hA5;
      3'd4: e[0] = 8'hD2;
      3'd5: e[0] = 8'h5A;
      default: e[0] = tb_tog ? 8'h4B : 8'hC3;
    endcase
    fld  = (kind == 3'd3) ? frame : {ep, dev};
    w    = {crc5_ref(fld), fld};
    e[1] = w[7:0];
    e[2] = w[15:8];
    nb   = (kind >= 3'd4) ? 1 : 3;
    lat  = (nb == 1) ? 1 : 12;

    @(negedge clk);
    chk(req_ready, "R9 idle ready", req_ready, 1);
    req_valid = 1'b1; req_kind = kind; dev_addr = dev; endp = ep; frame_num = frame;
    @(negedge clk);
    if (poke) begin
      req_kind = 3'd4; dev_addr = ~dev; endp = ~ep; frame_num = ~frame;
    end else begin
      req_valid = 1'b0;
    end
    n = 1; idx = 0; first = 0; hold_pending = 0; held = '0;
    while (idx < nb && n < 100) begin
      out_ready = stall ? (n % 3 != 0) : 1'b1;
      if (hold_pending) chk(out_valid && out_data == held, "R7 hold", out_data, held);
      hold_pending = 0;
      if (out_valid) begin
        if (first == 0) first = n;
        if (idx == 0)      tag = (kind == 3'd6) ? "R10 data pid" : "R1 pid";
        else if (idx == 1) tag = (kind == 3'd3) ? "R5 frame low" : "R3 field low";
        else               tag = "R4 crc byte";
        chk(out_data == e[idx], tag, out_data, e[idx]);
        chk(out_last == (idx == nb - 1), "R8 last flag", out_last, (idx == nb - 1));
        if (out_ready) begin
          idx++;
          if (idx == nb) req_valid = 1'b0;
        end else begin
          hold_pending = 1; held = out_data;
        end
      end
      @(negedge clk); n++;
    end
    chk(first == lat, "R6 latency", first, lat);
    chk(done, "R8 done high", done, 1);
    chk(!out_valid && req_ready, "R9 back to idle", {out_valid, req_ready}, 2'b01);
    out_ready = 1'b0;
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
    if (kind == 3'd6) tb_tog = !tb_tog;
    if (kind <= 3'd2) tb_tog = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; dev_addr = '0; endp = '0;
    frame_num = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid && req_ready && !done, "R12 reset state", {out_valid, req_ready, done}, 3'b010);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 / R11 sequence-bit interplay
    run_pkt(3'd6, 0, 0, 0, 0, 0);
    run_pkt(3'd6, 0, 0, 0, 1, 0);
    run_pkt(3'd6, 0, 0, 0, 0, 0);
    run_pkt(3'd4, 0, 0, 0, 0, 0);
    run_pkt(3'd6, 0, 0, 0, 0, 0);
    run_pkt(3'd3, 0, 0, 11'h2A, 0, 0);
    run_pkt(3'd5, 0, 0, 0, 1, 0);
    run_pkt(3'd6, 0, 0, 0, 0, 0);
    run_pkt(3'd0, 7'h05, 4'h1, 0, 0, 0);
    run_pkt(3'd6, 0, 0, 0, 0, 0);
    run_pkt(3'd6, 0, 0, 0, 0, 0);
    run_pkt(3'd2, 7'h7F, 4'hF, 0, 0, 0);
    run_pkt(3'd6, 0, 0, 0, 0, 0);

    // R3 / R4: every address and endpoint with IN
    for (int v = 0; v < 2048; v++) begin
      logic [10:0] vv = 11'(v);
      run_pkt(3'd1, vv[6:0], vv[10:7], 0, (v % 5 == 0), 0);
    end
    for (int v = 0; v < 2048; v += 41) begin
      logic [10:0] vv = 11'(v);
      run_pkt(3'd0, vv[6:0], vv[10:7], 0, (v % 2 == 0), 0);
      run_pkt(3'd2, vv[6:0], vv[10:7], 0, 0, 0);
    end

    // R5 start-of-frame over a spread of frame numbers
    for (int f = 0; f < 2048; f += 13) run_pkt(3'd3, 0, 0, 11'(f), (f % 3 == 0), 0);
    run_pkt(3'd3, 0, 0, 11'h7FF, 0, 0);

    // R9 requests during busy are not taken
    run_pkt(3'd1, 7'h12, 4'h3, 0, 1, 1);
    run_pkt(3'd6, 0, 0, 0, 0, 1);
    run_pkt(3'd3, 0, 0, 11'h155, 0, 1);

    // R2 reserved code 7 ignored
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd7; out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(!out_valid && !done && req_ready, "R2 reserved ignored", {out_valid, done, req_ready}, 3'b001);
      @(negedge clk);
    end
    out_ready = 1'b0;
    run_pkt(3'd6, 0, 0, 0, 0, 0);

    // R12 reset clears sequence bit and aborts a packet
    if (!tb_tog) run_pkt(3'd6, 0, 0, 0, 0, 0);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && req_ready && !done, "R12 reset mid packet", {out_valid, req_ready, done}, 3'b010);
    rst_n = 1'b1;
    tb_tog = 1'b0;
    repeat (14) begin
      @(negedge clk);
      chk(!out_valid, "R12 aborted packet stays quiet", out_valid, 0);
    end
    run_pkt(3'd6, 0, 0, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule